// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Unit

This block keeps four 16-bit segment base registers (extra, code, stack, data). It turns a logical address into a 20-bit linear address for a 1 MB byte-addressed bus. A logical address is one chosen segment register plus a 16-bit offset. The segment value is moved up by four bit positions, so every segment begins on a 16-byte paragraph. The zero-extended offset is then added to it. The sum is kept to 20 bits, so an address past the top of the space wraps back to the bottom.

Software or a sequencer loads segment registers through a synchronous write port. A translation is requested by strobing `req_valid` with a segment select and an offset. The result is registered. A small output state machine has two states. `ST_IDLE` means no result is presented. `ST_EMIT` means `lin_addr` carries a fresh translation. On any clock edge where `req_valid` is high, the machine goes to `ST_EMIT` from either state (transitions IDLE→EMIT and EMIT→EMIT). On any edge where `req_valid` is low, it goes to `ST_IDLE` (transitions EMIT→IDLE and IDLE→IDLE).

Top module: `seg_xlat_unit`

## Requirements
- R1: An active-high synchronous reset sets all four segment registers to zero, `lin_valid` to 0 and `lin_addr` to 0. After reset, a translation from any register returns the offset unchanged.
- R2: `lin_addr` equals (segment << 4) + zero-extended offset, computed to 20 bits. Its low four bits therefore always equal the low four bits of the offset.
- R3: Segment 0x1A7B with offset 0x7C7F produces linear address 0x2242F.
- R4: A sum wider than 20 bits is truncated modulo 2^20. Segment 0xFFFF with offset 0x0010 yields 0x00000, and 0xFFFF:0xFFFF yields 0x0FFEF.
- R5: The select code on `req_sel` and `wr_sel` is 2'b00 for extra, 2'b01 for code, 2'b10 for stack and 2'b11 for data.
- R6: Segments may overlap. Registers loaded with the same value give identical results for equal offsets.
- R7: `lin_valid` is high in the cycle after a clock edge that sampled `req_valid` high, and low in the cycle after an edge that sampled it low.
- R8: When a write and a translation name the same register in the same cycle, the translation uses the old value. The new value applies from the next cycle.
- R9: A write changes only the register named by `wr_sel`. The other three keep their values.
- R10: While no request is sampled, `lin_addr` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write (R5 code) |
| wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 2 | Register to translate through (R5 code) |
| req_off | input | 16 | Offset within the segment |
| lin_valid | output | 1 | Registered result valid |
| lin_addr | output | 20 | Registered linear address |

## Verification
The bench aims at three risks: the wrap at the top of the 1 MB space, the select decode, and the race between a write and a translation of the same register. If the carry were kept, or the shift width wrong, the known example and the 0xFFFF cases would give addresses off by a paragraph multiple. If the select decode were swapped, distinct values loaded into each register would come back from the wrong slot. If the write were bypassed into the read path, the same-cycle case would return the new base one cycle too early. The bench also checks two more faults. A write decode that hits more than one register would corrupt the untouched registers, and the bench reads them back through translations. An output stage that does not hold state would show up on cycles with no request, as a stuck valid or a drifting address.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int PARA_SH = 4;
    localparam int ADDR_W = 20;
    localparam int NSEG   = 4;
    localparam int SEL_W  = $clog2(NSEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [SEG_W-1:0] bank_q [NSEG];

    for (genvar gi = 0; gi < NSEG; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[gi] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(gi))) begin
                bank_q[gi] <= wr_data;
            end
        end
    end

    // Read returns the stored value only; a write in flight is not forwarded.
    always_comb begin
        rd_data = bank_q[rd_sel];
    end

endmodule

// File: rtl/para_adder.sv
module para_adder #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int PARA_SH = 4,
    parameter int ADDR_W  = 20
) (
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  off_val,
    output logic [ADDR_W-1:0] sum
);

    localparam int BASE_W = SEG_W + PARA_SH;

    logic [BASE_W-1:0] base_raw;
    logic [ADDR_W-1:0] base_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        base_raw = {seg_val, {PARA_SH{1'b0}}};
        base_ext = ADDR_W'(base_raw);
        off_ext  = ADDR_W'(off_val);
        sum      = base_ext + off_ext; // carry out of ADDR_W is dropped
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [OFF_W-1:0]  req_off,
    output logic              lin_valid,
    output logic [ADDR_W-1:0] lin_addr
);

    out_state_e        state_q, state_d;
    logic [SEG_W-1:0]  seg_rd;
    logic [ADDR_W-1:0] sum_w;
    logic [ADDR_W-1:0] addr_q;

    seg_bank #(
        .SEG_W (SEG_W),
        .NSEG  (NSEG)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (req_sel),
        .rd_data (seg_rd)
    );

    para_adder #(
        .SEG_W   (SEG_W),
        .OFF_W   (OFF_W),
        .PARA_SH (PARA_SH),
        .ADDR_W  (ADDR_W)
    ) u_add (
        .seg_val (seg_rd),
        .off_val (req_off),
        .sum     (sum_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                addr_q <= sum_w;
            end
        end
    end

    always_comb begin
        lin_valid = (state_q == ST_EMIT);
        lin_addr  = addr_q;
    end

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
    import seg_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic              req_valid,
    input logic [SEL_W-1:0]  req_sel,
    input logic [OFF_W-1:0]  req_off,
    input logic              lin_valid,
    input logic [ADDR_W-1:0] lin_addr
);

    p_valid_after_req_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> lin_valid);

    p_quiet_after_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !lin_valid);

    p_addr_held_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(lin_addr));

    // Paragraph-aligned base leaves the offset's low nibble untouched
    p_low_nibble_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (lin_addr[PARA_SH-1:0] == $past(req_off[PARA_SH-1:0])));

    // Repeating a request with no intervening write returns the same address
    p_repeat_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(req_valid) && !$past(wr_en)
         && (req_sel == $past(req_sel)) && (req_off == $past(req_off)))
        |=> (lin_addr == $past(lin_addr)));

endmodule

bind seg_xlat_unit seg_xlat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .req_off   (req_off),
    .lin_valid (lin_valid),
    .lin_addr  (lin_addr)
);

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [1:0]  req_sel;
    logic [15:0] req_off;
    logic        lin_valid;
    logic [19:0] lin_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_xlat_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
        .lin_valid(lin_valid), .lin_addr(lin_addr)
    );

    function automatic logic [19:0] model(input logic [15:0] s, input logic [15:0] o);
        logic [19:0] b;
        logic [19:0] e;
        b = {s, 4'h0};
        e = {4'h0, o};
        return b + e;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_seg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic xlat(input string tag, input logic [1:0] s, input logic [15:0] o,
                        input logic [19:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(lin_valid), 32'd1);
        check({tag, " addr"}, 32'(lin_addr), 32'(exp));
    endtask

    task automatic t_reset_r1();
        check("R1 valid after reset", 32'(lin_valid), 32'd0);
        check("R1 addr after reset", 32'(lin_addr), 32'd0);
        for (int i = 0; i < 4; i++) xlat("R1 zero base", 2'(i), 16'h1234, 20'h01234);
    endtask

    task automatic t_example_r3();
        write_seg(2'b11, 16'h1A7B);
        xlat("R3 example", 2'b11, 16'h7C7F, 20'h2242F);
        xlat("R2 model", 2'b11, 16'h0005, model(16'h1A7B, 16'h0005));
    endtask

    task automatic t_wrap_r4();
        write_seg(2'b10, 16'hFFFF);
        xlat("R4 wrap to zero", 2'b10, 16'h0010, 20'h00000);
        xlat("R4 wrap max", 2'b10, 16'hFFFF, 20'h0FFEF);
        xlat("R4 no wrap", 2'b10, 16'h000F, 20'hFFFFF);
    endtask

    task automatic t_select_r5_r9();
        write_seg(2'b00, 16'h1000); // extra
        write_seg(2'b01, 16'h2000); // code
        write_seg(2'b10, 16'h3000); // stack
        write_seg(2'b11, 16'h4000); // data
        xlat("R5 extra 00", 2'b00, 16'h0001, 20'h10001);
        xlat("R5 code 01", 2'b01, 16'h0002, 20'h20002);
        xlat("R5 stack 10", 2'b10, 16'h0003, 20'h30003);
        xlat("R5 data 11", 2'b11, 16'h0004, 20'h40004);
        write_seg(2'b01, 16'h0ABC);
        xlat("R9 code updated", 2'b01, 16'h0000, 20'h0ABC0);
        xlat("R9 extra kept", 2'b00, 16'h0000, 20'h10000);
        xlat("R9 stack kept", 2'b10, 16'h0000, 20'h30000);
        xlat("R9 data kept", 2'b11, 16'h0000, 20'h40000);
    endtask

    task automatic t_overlap_r6();
        write_seg(2'b00, 16'h0777);
        write_seg(2'b10, 16'h0777);
        xlat("R6 overlap extra", 2'b00, 16'h9999, model(16'h0777, 16'h9999));
        xlat("R6 overlap stack", 2'b10, 16'h9999, model(16'h0777, 16'h9999));
    endtask

    task automatic t_valid_r7_r10();
        logic [19:0] held;
        xlat("R7 single", 2'b01, 16'h0040, model(16'h0ABC, 16'h0040));
        held = lin_addr;
        @(negedge clk);
        check("R7 idle valid low", 32'(lin_valid), 32'd0);
        check("R10 addr held", 32'(lin_addr), 32'(held));
        req_off = 16'hFFFF; req_sel = 2'b10;
        @(negedge clk);
        check("R10 held with moving inputs", 32'(lin_addr), 32'(held));
        req_valid = 1'b1; req_sel = 2'b00; req_off = 16'h0001;
        @(negedge clk);
        req_sel = 2'b11; req_off = 16'h0002;
        check("R7 back-to-back first", 32'(lin_addr), 32'(model(16'h0777, 16'h0001)));
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 back-to-back valid", 32'(lin_valid), 32'd1);
        check("R7 back-to-back second", 32'(lin_addr), 32'(model(16'h4000, 16'h0002)));
    endtask

    task automatic t_same_cycle_r8();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'b11; wr_data = 16'h5555;
        req_valid = 1'b1; req_sel = 2'b11; req_off = 16'h0100;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R8 old value used", 32'(lin_addr), 32'(model(16'h4000, 16'h0100)));
        xlat("R8 new value next", 2'b11, 16'h0100, model(16'h5555, 16'h0100));
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        req_valid = 1'b0; req_sel = '0; req_off = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_example_r3();
        t_wrap_r4();
        t_select_r5_r9();
        t_overlap_r6();
        t_valid_r7_r10();
        t_same_cycle_r8();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule